// File: doc/BRIEF.md
# Asymmetric Dead-Time Generator for Half-Bridge Gate Enables

This block turns one PWM command into two gate enables, one for the high-side switch and one for the low-side switch of a synchronous buck stage. Whenever the command changes, the side that is on is switched off at once. The other side is switched on only after a dead interval, during which both enables are low. The two switching directions use separate dead-time tables. One table covers turning the high side off and the low side on. The other covers turning the low side off and the high side on.

A 3-bit strap code picks the table entry. Each entry is given in picoseconds as a parameter and is converted to a whole number of clock cycles, rounded up, using the clock-period parameter. A built-in minimum, equal to the first entry of each table, always applies. When the command reverses during a dead interval, the sequence restarts toward the newly requested side and counts that side's full delay. A global driver enable forces both outputs low in the same cycle and cancels any pending delay.

Top module: `dead_time_gen`

## Requirements
- R1: `dt_code` is read as {bit2, bit1, bit0}. When bit0 is 1, the table index is {bit2, bit1}. The supported codes 001, 011, 101 and 111 therefore select index 0, 1, 2 and 3.
- R2: High-side-off to low-side-on delay. After the cycle in which `hs_on` falls, `ls_on` rises after exactly N cycles with both outputs low. N is ceil(T/CLK_PERIOD_PS). With the defaults (2500 ps), T is 7500, 18000, 32000 or 45000 ps for index 0 to 3, which gives 3, 8, 13 and 18 cycles.
- R3: Low-side-off to high-side-on delay. This works in the same way, with T equal to 5000, 18000, 32000 or 44000 ps for index 0 to 3, which gives 2, 8, 13 and 18 cycles.
- R4: Any code with bit0 = 0 applies only the built-in minimum in both directions: 3 cycles toward the low side and 2 cycles toward the high side with the defaults.
- R5: The applied delay in each direction is the larger of the built-in minimum (index 0 of that direction) and the strapped entry. No dead interval is ever shorter than the minimum.
- R6: `hs_on` and `ls_on` are never high in the same cycle.
- R7: If `pwm_cmd` reverses while a dead interval is counting, that interval is abandoned. The interval toward the new side is counted in full from the clock edge that samples the reversal, and the abandoned side never turns on.
- R8: While `drv_en` is low, both outputs are low in that same cycle, without waiting for a clock edge, and any pending delay is cancelled. When `drv_en` returns high, the requested side turns on only after its full delay (R2/R3), counted from the first enabled edge.
- R9: After reset both outputs are low.
- R10: `hs_on` is high only if `pwm_cmd` was 1 at the preceding clock edge. `ls_on` is high only if it was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_cmd | input | 1 | PWM command: 1 requests the high side, 0 requests the low side |
| drv_en | input | 1 | Global driver enable; low forces both outputs low |
| dt_code | input | 3 | Dead-time strap code, logical bit values |
| hs_on | output | 1 | High-side gate enable |
| ls_on | output | 1 | Low-side gate enable |

## Verification
Two kinds of internal fault show up directly at the ports. A counter loaded with the wrong table entry, or a direction mix-up, changes the count of both-low cycles between one output falling and the other rising. The difference appears on the very first transition after the strap code is set. A sequencer that does not abandon a pending interval, or does not clear it on disable, turns on the wrong side or turns on early. This is visible within one dead interval, at most 18 cycles with the defaults. An overlap or a missed disable is visible in the same cycle it happens.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_HS    = 3'd1,
    ST_LS    = 3'd2,
    ST_TO_HS = 3'd3,
    ST_TO_LS = 3'd4
  } dtg_state_e;

  localparam int DIR_TO_LS = 0;
  localparam int DIR_TO_HS = 1;
  localparam int N_DIR     = 2;

  function automatic int ps_to_cycles(input int ps, input int period_ps);
    int c;
    c = (ps + period_ps - 1) / period_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dtg_delay_sel.sv
module dtg_delay_sel #(
  parameter int CNT_W  = 5,
  parameter int H2L_C0 = 3,
  parameter int H2L_C1 = 8,
  parameter int H2L_C2 = 13,
  parameter int H2L_C3 = 18,
  parameter int L2H_C0 = 2,
  parameter int L2H_C1 = 8,
  parameter int L2H_C2 = 13,
  parameter int L2H_C3 = 18
) (
  input  logic [2:0]       code,
  output logic [CNT_W-1:0] h2l_cyc,
  output logic [CNT_W-1:0] l2h_cyc
);

  localparam logic [CNT_W-1:0] H2L_MIN = CNT_W'(H2L_C0);
  localparam logic [CNT_W-1:0] L2H_MIN = CNT_W'(L2H_C0);

  logic [1:0]       idx;
  logic [CNT_W-1:0] h2l_raw;
  logic [CNT_W-1:0] l2h_raw;

  assign idx = code[2:1];

  always_comb begin
    case (idx)
      2'd0:    begin h2l_raw = CNT_W'(H2L_C0); l2h_raw = CNT_W'(L2H_C0); end
      2'd1:    begin h2l_raw = CNT_W'(H2L_C1); l2h_raw = CNT_W'(L2H_C1); end
      2'd2:    begin h2l_raw = CNT_W'(H2L_C2); l2h_raw = CNT_W'(L2H_C2); end
      default: begin h2l_raw = CNT_W'(H2L_C3); l2h_raw = CNT_W'(L2H_C3); end
    endcase
  end

  // Strapped value only counts when bit0 marks a supported code; never below the built-in floor.
  always_comb begin
    if (!code[0]) begin
      h2l_cyc = H2L_MIN;
      l2h_cyc = L2H_MIN;
    end else begin
      h2l_cyc = (h2l_raw > H2L_MIN) ? h2l_raw : H2L_MIN;
      l2h_cyc = (l2h_raw > L2H_MIN) ? l2h_raw : L2H_MIN;
    end
  end

endmodule

// File: rtl/dtg_edge_timer.sv
module dtg_edge_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             clr,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = load | clr | (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/dtg_seq.sv
module dtg_seq
  import dtg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pwm_cmd,
  input  logic                 drv_en,
  input  logic [N_DIR-1:0]     tmr_last,
  output logic [N_DIR-1:0]     tmr_load,
  output logic [N_DIR-1:0]     tmr_clr,
  output logic                 hs_state,
  output logic                 ls_state
);

  dtg_state_e st_q;
  dtg_state_e st_d;

  always_comb begin
    st_d     = st_q;
    tmr_load = '0;
    tmr_clr  = '0;
    if (!drv_en) begin
      st_d    = ST_OFF;
      tmr_clr = '1;
    end else begin
      case (st_q)
        ST_OFF: begin
          if (pwm_cmd) begin
            tmr_load[DIR_TO_HS] = 1'b1;
            st_d = ST_TO_HS;
          end else begin
            tmr_load[DIR_TO_LS] = 1'b1;
            st_d = ST_TO_LS;
          end
        end
        ST_HS: begin
          if (!pwm_cmd) begin
            tmr_load[DIR_TO_LS] = 1'b1;
            st_d = ST_TO_LS;
          end
        end
        ST_LS: begin
          if (pwm_cmd) begin
            tmr_load[DIR_TO_HS] = 1'b1;
            st_d = ST_TO_HS;
          end
        end
        ST_TO_LS: begin
          if (pwm_cmd) begin
            tmr_clr[DIR_TO_LS]  = 1'b1;
            tmr_load[DIR_TO_HS] = 1'b1;
            st_d = ST_TO_HS;
          end else if (tmr_last[DIR_TO_LS]) begin
            st_d = ST_LS;
          end
        end
        ST_TO_HS: begin
          if (!pwm_cmd) begin
            tmr_clr[DIR_TO_HS]  = 1'b1;
            tmr_load[DIR_TO_LS] = 1'b1;
            st_d = ST_TO_LS;
          end else if (tmr_last[DIR_TO_HS]) begin
            st_d = ST_HS;
          end
        end
        default: st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      st_q <= ST_OFF;
    else
      st_q <= st_d;
  end

  assign hs_state = (st_q == ST_HS);
  assign ls_state = (st_q == ST_LS);

endmodule

// File: rtl/dead_time_gen.sv
module dead_time_gen
  import dtg_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 2500,
  parameter int H2L_T0_PS     = 7500,
  parameter int H2L_T1_PS     = 18000,
  parameter int H2L_T2_PS     = 32000,
  parameter int H2L_T3_PS     = 45000,
  parameter int L2H_T0_PS     = 5000,
  parameter int L2H_T1_PS     = 18000,
  parameter int L2H_T2_PS     = 32000,
  parameter int L2H_T3_PS     = 44000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwm_cmd,
  input  logic       drv_en,
  input  logic [2:0] dt_code,
  output logic       hs_on,
  output logic       ls_on
);

  localparam int H2L_C0 = ps_to_cycles(H2L_T0_PS, CLK_PERIOD_PS);
  localparam int H2L_C1 = ps_to_cycles(H2L_T1_PS, CLK_PERIOD_PS);
  localparam int H2L_C2 = ps_to_cycles(H2L_T2_PS, CLK_PERIOD_PS);
  localparam int H2L_C3 = ps_to_cycles(H2L_T3_PS, CLK_PERIOD_PS);
  localparam int L2H_C0 = ps_to_cycles(L2H_T0_PS, CLK_PERIOD_PS);
  localparam int L2H_C1 = ps_to_cycles(L2H_T1_PS, CLK_PERIOD_PS);
  localparam int L2H_C2 = ps_to_cycles(L2H_T2_PS, CLK_PERIOD_PS);
  localparam int L2H_C3 = ps_to_cycles(L2H_T3_PS, CLK_PERIOD_PS);
  localparam int MAX_C  = imax(imax(imax(H2L_C0, H2L_C1), imax(H2L_C2, H2L_C3)),
                               imax(imax(L2H_C0, L2H_C1), imax(L2H_C2, L2H_C3)));
  localparam int CNT_W  = $clog2(MAX_C + 1);

  logic [CNT_W-1:0] h2l_cyc;
  logic [CNT_W-1:0] l2h_cyc;
  logic [CNT_W-1:0] tmr_val [N_DIR];
  logic [N_DIR-1:0] tmr_load;
  logic [N_DIR-1:0] tmr_clr;
  logic [N_DIR-1:0] tmr_last;
  logic             hs_state;
  logic             ls_state;

  dtg_delay_sel #(
    .CNT_W (CNT_W),
    .H2L_C0(H2L_C0), .H2L_C1(H2L_C1), .H2L_C2(H2L_C2), .H2L_C3(H2L_C3),
    .L2H_C0(L2H_C0), .L2H_C1(L2H_C1), .L2H_C2(L2H_C2), .L2H_C3(L2H_C3)
  ) sel_i (
    .code   (dt_code),
    .h2l_cyc(h2l_cyc),
    .l2h_cyc(l2h_cyc)
  );

  assign tmr_val[DIR_TO_LS] = h2l_cyc;
  assign tmr_val[DIR_TO_HS] = l2h_cyc;

  for (genvar g = 0; g < N_DIR; g++) begin : g_dir
    dtg_edge_timer #(.CNT_W(CNT_W)) tmr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load[g]),
      .clr     (tmr_clr[g]),
      .load_val(tmr_val[g]),
      .last    (tmr_last[g])
    );
  end

  dtg_seq seq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwm_cmd (pwm_cmd),
    .drv_en  (drv_en),
    .tmr_last(tmr_last),
    .tmr_load(tmr_load),
    .tmr_clr (tmr_clr),
    .hs_state(hs_state),
    .ls_state(ls_state)
  );

  // Enable gating is combinational so a disable takes effect in the same cycle.
  assign hs_on = hs_state & drv_en;
  assign ls_on = ls_state & drv_en;

endmodule

// File: rtl/dtg_chk.sv
module dtg_chk
  import dtg_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 2500,
  parameter int H2L_T0_PS     = 7500,
  parameter int H2L_T1_PS     = 18000,
  parameter int H2L_T2_PS     = 32000,
  parameter int H2L_T3_PS     = 45000,
  parameter int L2H_T0_PS     = 5000,
  parameter int L2H_T1_PS     = 18000,
  parameter int L2H_T2_PS     = 32000,
  parameter int L2H_T3_PS     = 44000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pwm_cmd,
  input logic       drv_en,
  input logic [2:0] dt_code,
  input logic       hs_on,
  input logic       ls_on
);

  localparam int H2L_MIN = ps_to_cycles(H2L_T0_PS, CLK_PERIOD_PS);
  localparam int L2H_MIN = ps_to_cycles(L2H_T0_PS, CLK_PERIOD_PS);

  function automatic int want_h2l(input logic [2:0] c);
    int t;
    case (c[2:1])
      2'd0: t = H2L_T0_PS;
      2'd1: t = H2L_T1_PS;
      2'd2: t = H2L_T2_PS;
      default: t = H2L_T3_PS;
    endcase
    return c[0] ? imax(H2L_MIN, ps_to_cycles(t, CLK_PERIOD_PS)) : H2L_MIN;
  endfunction

  function automatic int want_l2h(input logic [2:0] c);
    int t;
    case (c[2:1])
      2'd0: t = L2H_T0_PS;
      2'd1: t = L2H_T1_PS;
      2'd2: t = L2H_T2_PS;
      default: t = L2H_T3_PS;
    endcase
    return c[0] ? imax(L2H_MIN, ps_to_cycles(t, CLK_PERIOD_PS)) : L2H_MIN;
  endfunction

  logic [7:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      gap_q <= '0;
    else if (hs_on || ls_on)
      gap_q <= '0;
    else if (gap_q != 8'hFF)
      gap_q <= gap_q + 8'd1;
  end

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_on && ls_on));

  assert_disable_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |-> (!hs_on && !ls_on));

  assert_h2l_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_on) |-> (int'(gap_q) >= want_h2l(dt_code)));

  assert_l2h_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_on) |-> (int'(gap_q) >= want_l2h(dt_code)));

  assert_floor_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hs_on) || $rose(ls_on)) |-> (int'(gap_q) >= ((L2H_MIN < H2L_MIN) ? L2H_MIN : H2L_MIN)));

  assert_hs_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hs_on |-> $past(pwm_cmd));

  assert_ls_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ls_on |-> !$past(pwm_cmd));

endmodule

bind dead_time_gen dtg_chk #(
  .CLK_PERIOD_PS(CLK_PERIOD_PS),
  .H2L_T0_PS(H2L_T0_PS), .H2L_T1_PS(H2L_T1_PS), .H2L_T2_PS(H2L_T2_PS), .H2L_T3_PS(H2L_T3_PS),
  .L2H_T0_PS(L2H_T0_PS), .L2H_T1_PS(L2H_T1_PS), .L2H_T2_PS(L2H_T2_PS), .L2H_T3_PS(L2H_T3_PS)
) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .pwm_cmd(pwm_cmd),
  .drv_en (drv_en),
  .dt_code(dt_code),
  .hs_on  (hs_on),
  .ls_on  (ls_on)
);

// File: tb/dead_time_gen_tb_top.sv
module dead_time_gen_tb_top;

  localparam int PERIOD_PS = 2500;

  logic       clk;
  logic       rst_n;
  logic       pwm_cmd;
  logic       drv_en;
  logic [2:0] dt_code;
  logic       hs_on;
  logic       ls_on;

  int checks;
  int errors;
  int overlaps;
  bit done;

  dead_time_gen dut_i (
    .clk(clk), .rst_n(rst_n), .pwm_cmd(pwm_cmd), .drv_en(drv_en),
    .dt_code(dt_code), .hs_on(hs_on), .ls_on(ls_on)
  );

  initial clk = 1'b0;
  always #10ns clk = ~clk;

  always @(negedge clk) if (rst_n && hs_on && ls_on) overlaps++;

  function automatic int cyc(input int ps);
    int c;
    c = (ps + PERIOD_PS - 1) / PERIOD_PS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int exp_gap(input logic [2:0] c, input bit to_hs);
    int h [4];
    int l [4];
    int i;
    int v;
    int fl;
    h = '{7500, 18000, 32000, 45000};
    l = '{5000, 18000, 32000, 44000};
    i = c[0] ? int'(c[2:1]) : 0;
    v  = to_hs ? cyc(l[i]) : cyc(h[i]);
    fl = to_hs ? cyc(l[0]) : cyc(h[0]);
    return (v > fl) ? v : fl;
  endfunction

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Counts samples with both outputs low until the wanted side turns on.
  task automatic measure(input bit to_hs, output int n, output bit wrong);
    n = 0;
    wrong = 1'b0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (to_hs ? ls_on : hs_on) wrong = 1'b1;
      if (to_hs ? hs_on : ls_on) return;
      n++;
    end
  endtask

  task automatic settle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    int  n;
    bit  wr;
    string tag;
    checks = 0; errors = 0; overlaps = 0; done = 1'b0;
    rst_n = 1'b0; pwm_cmd = 1'b1; drv_en = 1'b1; dt_code = 3'b001;
    settle(3);
    // R9: reset state
    check("R9 hs_on in reset", int'(hs_on), 0);
    check("R9 ls_on in reset", int'(ls_on), 0);
    drv_en = 1'b0;
    rst_n  = 1'b1;
    settle(2);

    // R1 R2 R3 R4 R5: sweep all eight strap codes
    for (int c = 0; c < 8; c++) begin
      tag = (c % 2 == 0) ? "R4" : "R1";
      drv_en  = 1'b0;
      pwm_cmd = 1'b1;
      dt_code = 3'(c);
      settle(3);
      check("R8 disabled hs", int'(hs_on), 0);
      drv_en = 1'b1;
      measure(1'b1, n, wr);
      check({tag, " R3 from off to hs"}, n, exp_gap(3'(c), 1'b1));
      settle(3);
      check("R10 steady hs", int'(hs_on), 1);
      pwm_cmd = 1'b0;
      measure(1'b0, n, wr);
      check({tag, " R2 hs->ls gap"}, n, exp_gap(3'(c), 1'b0));
      check("R5 ls gap floor", int'(n >= 3), 1);
      settle(3);
      check("R10 steady ls", int'(ls_on), 1);
      pwm_cmd = 1'b1;
      measure(1'b1, n, wr);
      check({tag, " R3 ls->hs gap"}, n, exp_gap(3'(c), 1'b1));
      check("R5 hs gap floor", int'(n >= 2), 1);
      settle(2);
    end

    // R7: reversal during a dead interval
    dt_code = 3'b111;
    pwm_cmd = 1'b0;
    settle(2);
    check("R7 hs off after request", int'(hs_on), 0);
    pwm_cmd = 1'b1;
    measure(1'b1, n, wr);
    check("R7 restart gap to hs", n, 18);
    check("R7 abandoned ls stayed off", int'(wr), 0);
    settle(3);

    // R8: immediate disable while high, then full delay after re-enable
    drv_en = 1'b0;
    #1ns;
    check("R8 hs low same cycle", int'(hs_on), 0);
    settle(3);
    drv_en = 1'b1;
    measure(1'b1, n, wr);
    check("R8 re-enable gap", n, 18);

    // R8: disable cancels a pending interval
    pwm_cmd = 1'b0;
    settle(5);
    drv_en = 1'b0;
    settle(30);
    check("R8 ls held off while disabled", int'(ls_on), 0);
    drv_en = 1'b1;
    measure(1'b0, n, wr);
    check("R8 cancelled then full gap", n, 18);

    check("R6 overlap samples", overlaps, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 100000; k++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule